// File: doc/BRIEF.md
# Interlocked Four-Phase Word Transmitter

This block hands a stream of data words from on-chip logic to a slow external host over a parallel bus. The transfer is fully interlocked with a request/acknowledge pair. Words enter through a valid/ready interface. For each accepted word, the block does four things in turn:

- It drives the word onto the bus.
- One clock later it raises a transmit strobe.
- It holds the strobe until the host's acknowledge is seen high, then drops it.
- It waits until the acknowledge is seen low again before it takes another word.

The host acknowledge is asynchronous to the block clock. It passes through a multi-stage synchronizer before the control logic uses it. An optional watchdog counter reports a host that stalls in either wait phase. The counter does not abort the transfer: the block keeps waiting. When the timeout parameter is set to zero, the counter is not built.

Top module: `hs_word_tx`

## Requirements
- R1: A word accepted on a clock edge where `in_valid` and `in_ready` are both high appears on `bus_data` after that edge. `xmit_strobe` rises one edge later, so the data leads the strobe by one full cycle.
- R2: Once raised, `xmit_strobe` stays high until the synchronized acknowledge is high, and falls on the next edge.
- R3: After the strobe falls, no new word is accepted until the synchronized acknowledge is low.
- R4: `in_ready` is high only when the block is idle, the strobe is low and the synchronized acknowledge is low.
- R5: `bus_data` changes only on an accepting edge or on reset. It holds its value through the strobe and acknowledge phases.
- R6: `host_ack_async` passes through SYNC_STAGES flip-flops. A rise of the acknowledge between two edges makes the strobe fall on the (SYNC_STAGES+1)-th following rising edge.
- R7: `timeout_err` goes high once the block has spent TIMEOUT_CYC clock edges in one wait phase (strobe-high or strobe-low). It stays high while that phase lasts and clears on the edge after the phase ends.
- R8: A synchronous, active-high `rst` returns the block to idle. After reset, `xmit_strobe`, `bus_data` and `timeout_err` are 0, and `in_ready` is 1 once the synchronized acknowledge is low.
- R9: `in_valid` and `in_data` have no effect while `in_ready` is low, and `bus_data` keeps the word in flight.
- R10: With TIMEOUT_CYC = 0 no watchdog is built, and `timeout_err` is constantly 0. The handshake is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Source offers a word |
| in_ready | output | 1 | Block takes the offered word on this edge |
| in_data | input | DATA_W | Offered word |
| bus_data | output | DATA_W | Parallel data bus to the host |
| xmit_strobe | output | 1 | Transmit request strobe to the host |
| host_ack_async | input | 1 | Asynchronous host acknowledge |
| timeout_err | output | 1 | Host has not responded within TIMEOUT_CYC cycles |

## Verification
A wrong control state shows up at the ports within one clock.

- A phase advanced too early drops the strobe before the synchronized acknowledge, or re-opens `in_ready` while the acknowledge is still high.
- A phase that fails to advance leaves the strobe stuck and raises `timeout_err` after TIMEOUT_CYC edges.
- A corrupted data register shows on `bus_data` at once, and again when the host model captures the word at the strobe rise.
- A wrong synchronizer depth moves the strobe fall by a whole cycle. The every-clock model comparison catches this on the first word.

// File: rtl/hs_tx_pkg.sv
package hs_tx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SETUP   = 2'd1,
      ST_WAIT_HI = 2'd2,
      ST_WAIT_LO = 2'd3
   } tx_state_t;

   function automatic int cnt_width(input int limit);
      return (limit > 0) ? $clog2(limit + 1) : 1;
   endfunction
endpackage

// File: rtl/hs_ack_sync.sv
module hs_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] shreg;

   always_ff @(posedge clk) begin
      if (rst) shreg <= '0;
      else     shreg <= {shreg[STAGES-2:0], d_async};
   end

   assign q_sync = shreg[STAGES-1];
endmodule

// File: rtl/hs_wait_timer.sv
module hs_wait_timer #(
   parameter int LIMIT = 1000,
   localparam int CNT_W = hs_tx_pkg::cnt_width(LIMIT)
) (
   input  logic clk,
   input  logic rst,
   input  logic wait_active,
   input  logic phase_done,
   output logic expired
);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || !wait_active || phase_done) cnt <= '0;
      else if (cnt != LIM)                   cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == LIM);
endmodule

// File: rtl/hs_tx_fsm.sv
module hs_tx_fsm
   import hs_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              ack_s,
   output logic              in_ready,
   output logic [DATA_W-1:0] bus_data,
   output logic              xmit_strobe,
   output logic              wait_active,
   output logic              phase_done
);
   tx_state_t state;
   logic      take;

   assign in_ready    = (state == ST_IDLE) && !xmit_strobe && !ack_s;
   assign take        = in_valid && in_ready;
   assign wait_active = (state == ST_WAIT_HI) || (state == ST_WAIT_LO);
   assign phase_done  = ((state == ST_WAIT_HI) && ack_s) ||
                        ((state == ST_WAIT_LO) && !ack_s);

   always_ff @(posedge clk) begin
      if (rst) begin
         state       <= ST_IDLE;
         bus_data    <= '0;
         xmit_strobe <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (take) begin
               bus_data <= in_data;
               state    <= ST_SETUP;
            end
            ST_SETUP: begin
               xmit_strobe <= 1'b1;
               state       <= ST_WAIT_HI;
            end
            ST_WAIT_HI: if (ack_s) begin
               xmit_strobe <= 1'b0;
               state       <= ST_WAIT_LO;
            end
            ST_WAIT_LO: if (!ack_s) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hs_word_tx.sv
module hs_word_tx #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int TIMEOUT_CYC = 1000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic [DATA_W-1:0] bus_data,
   output logic              xmit_strobe,
   input  logic              host_ack_async,
   output logic              timeout_err
);
   if (DATA_W < 1) begin : g_bad_width
      $error("hs_word_tx: DATA_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hs_word_tx: SYNC_STAGES must be at least 2");
   end
   if (TIMEOUT_CYC < 0) begin : g_bad_timeout
      $error("hs_word_tx: TIMEOUT_CYC must not be negative");
   end

   logic ack_s;
   logic wait_active;
   logic phase_done;

   hs_ack_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rst     (rst),
      .d_async (host_ack_async),
      .q_sync  (ack_s)
   );

   hs_tx_fsm #(.DATA_W(DATA_W)) fsm_i (
      .clk         (clk),
      .rst         (rst),
      .in_valid    (in_valid),
      .in_data     (in_data),
      .ack_s       (ack_s),
      .in_ready    (in_ready),
      .bus_data    (bus_data),
      .xmit_strobe (xmit_strobe),
      .wait_active (wait_active),
      .phase_done  (phase_done)
   );

   if (TIMEOUT_CYC > 0) begin : g_timer
      hs_wait_timer #(.LIMIT(TIMEOUT_CYC)) timer_i (
         .clk         (clk),
         .rst         (rst),
         .wait_active (wait_active),
         .phase_done  (phase_done),
         .expired     (timeout_err)
      );
   end else begin : g_no_timer
      assign timeout_err = 1'b0;
   end
endmodule

// File: rtl/hs_word_tx_chk.sv
module hs_word_tx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] bus_data,
   input logic              xmit_strobe,
   input logic              ack_sync,
   input logic              wait_active,
   input logic              timeout_err
);
   p_data_lead_r1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !xmit_strobe);

   p_rise_stable_r1: assert property (@(posedge clk) disable iff (rst)
      $rose(xmit_strobe) |-> $stable(bus_data));

   p_hold_strobe_r2: assert property (@(posedge clk) disable iff (rst)
      (xmit_strobe && !ack_sync) |=> xmit_strobe);

   p_drop_strobe_r2: assert property (@(posedge clk) disable iff (rst)
      (xmit_strobe && ack_sync) |=> !xmit_strobe);

   p_ready_idle_r4: assert property (@(posedge clk) disable iff (rst)
      in_ready |-> (!xmit_strobe && !ack_sync));

   p_no_reissue_r3: assert property (@(posedge clk) disable iff (rst)
      (!xmit_strobe && ack_sync) |-> !in_ready);

   p_bus_stable_r5: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && in_ready) |=> $stable(bus_data));

   p_err_in_wait_r7: assert property (@(posedge clk) disable iff (rst)
      !wait_active |-> !timeout_err);

   p_reset_state_r8: assert property (@(posedge clk)
      rst |=> (!xmit_strobe && bus_data == '0 && !timeout_err));
endmodule

bind hs_word_tx hs_word_tx_chk #(.DATA_W(DATA_W)) chk_i (
   .clk         (clk),
   .rst         (rst),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .bus_data    (bus_data),
   .xmit_strobe (xmit_strobe),
   .ack_sync    (ack_s),
   .wait_active (wait_active),
   .timeout_err (timeout_err)
);

// File: tb/hs_word_tx_tb_top.sv
`timescale 1ns/1ps
module hs_word_tx_tb_top;
   localparam int  DATA_W   = 8;
   localparam int  STAGES   = 2;
   localparam int  LIMIT    = 16;
   localparam time CLK_HALF = 5ns;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [DATA_W-1:0] in_data = '0;
   logic host_ack = 1'b0;
   logic in_ready, xmit_strobe, timeout_err;
   logic [DATA_W-1:0] bus_data;
   logic nt_ready, nt_strobe, nt_err;
   logic [DATA_W-1:0] nt_bus;

   always #(CLK_HALF) clk = ~clk;

   hs_word_tx #(.DATA_W(DATA_W), .SYNC_STAGES(STAGES), .TIMEOUT_CYC(LIMIT)) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .bus_data(bus_data), .xmit_strobe(xmit_strobe),
      .host_ack_async(host_ack), .timeout_err(timeout_err));

   hs_word_tx #(.DATA_W(DATA_W), .SYNC_STAGES(STAGES), .TIMEOUT_CYC(0)) dut_nt (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(nt_ready),
      .in_data(in_data), .bus_data(nt_bus), .xmit_strobe(nt_strobe),
      .host_ack_async(host_ack), .timeout_err(nt_err));

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_phase = 0;                 // 0 idle, 1 setup, 2 strobe high, 3 strobe low
   bit [DATA_W-1:0] m_bus = '0;
   bit m_strobe = 0;
   int m_wait = 0;                  // edges spent in the current wait phase
   bit hist[$];                     // samples of host_ack, oldest first
   bit [DATA_W-1:0] exp_q[$];
   bit accepted_last = 0;

   initial begin
      for (int i = 0; i < STAGES; i++) hist.push_back(1'b0);
   end

   function automatic bit m_ack();
      return hist[0];
   endfunction

   function automatic bit m_ready();
      return (m_phase == 0) && !m_strobe && !m_ack();
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_phase = 0; m_bus = '0; m_strobe = 0; m_wait = 0;
         hist.delete();
         for (int i = 0; i < STAGES; i++) hist.push_back(1'b0);
         exp_q.delete();
         accepted_last = 0;
      end else begin
         bit a, acc, waiting, done;
         a = m_ack();
         acc = m_ready() && in_valid;
         waiting = (m_phase == 2) || (m_phase == 3);
         done = (m_phase == 2 && a) || (m_phase == 3 && !a);
         if (!waiting || done) m_wait = 0;
         else if (m_wait < LIMIT) m_wait++;
         case (m_phase)
            0: if (acc) begin m_bus = in_data; exp_q.push_back(in_data); m_phase = 1; end
            1: begin m_strobe = 1; m_phase = 2; end
            2: if (a) begin m_strobe = 0; m_phase = 3; end
            default: if (!a) m_phase = 0;
         endcase
         accepted_last = acc;
         hist.push_back(host_ack);
         void'(hist.pop_front());
      end
   end

   // ---------------- host model, source, comparison ----------------
   int host_delay = 0;
   int host_cnt = 0;
   bit prev_strobe = 0;
   bit err_seen = 0;
   bit src_gap = 0;
   bit [DATA_W-1:0] src_q[$];
   int cyc = 0;

   always @(negedge clk) begin
      cyc++;
      if (!rst) begin
         chk(bus_data == m_bus, "R5 R9 R1 bus_data", bus_data, m_bus);
         chk(xmit_strobe == m_strobe, "R2 R6 xmit_strobe", xmit_strobe, m_strobe);
         chk(in_ready == m_ready(), "R4 R3 in_ready", in_ready, m_ready());
         chk(timeout_err == (m_wait == LIMIT), "R7 timeout_err", timeout_err, (m_wait == LIMIT));
         chk(nt_err == 1'b0, "R10 timeout_err without watchdog", nt_err, 0);
         chk(nt_strobe == xmit_strobe && nt_bus == bus_data, "R10 handshake unchanged",
             {nt_strobe, nt_bus}, {xmit_strobe, bus_data});
         if (timeout_err) err_seen = 1;
         if (xmit_strobe && !prev_strobe) begin
            if (exp_q.size() > 0) begin
               bit [DATA_W-1:0] w;
               w = exp_q.pop_front();
               chk(bus_data == w, "R1 word at strobe rise", bus_data, w);
            end else chk(0, "R1 strobe without accepted word", 1, 0);
         end
      end
      prev_strobe = xmit_strobe;
      // host: follow the strobe after host_delay cycles
      if (xmit_strobe != host_ack) begin
         if (host_cnt >= host_delay) begin host_ack = xmit_strobe; host_cnt = 0; end
         else host_cnt++;
      end else host_cnt = 0;
      // source
      if (accepted_last && !rst && src_q.size() > 0) void'(src_q.pop_front());
      accepted_last = 0;
      if (src_q.size() > 0 && !(src_gap && cyc[0])) begin
         in_valid = 1'b1;
         in_data  = in_ready ? src_q[0] : DATA_W'(cyc * 37) ^ 8'hA5;
      end else begin
         in_valid = 1'b0;
         in_data  = DATA_W'(cyc * 13);
      end
   end

   task automatic drain();
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (src_q.size() == 0 && m_phase == 0 && !host_ack && !xmit_strobe) break;
      end
      repeat (4) @(negedge clk);
   endtask

   initial begin : wdog
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      #1;
      chk(xmit_strobe == 0, "R8 strobe after reset", xmit_strobe, 0);
      chk(bus_data == 0, "R8 bus after reset", bus_data, 0);
      chk(timeout_err == 0, "R8 err after reset", timeout_err, 0);
      chk(in_ready == 1, "R8 ready after reset", in_ready, 1);

      // fast host, back-to-back words
      host_delay = 0;
      for (int i = 0; i < 6; i++) src_q.push_back(DATA_W'(8'h11 * (i + 1)));
      drain();

      // slower host, gaps in the source, junk data while not ready (R9)
      host_delay = 3; src_gap = 1;
      src_q.push_back(8'h00); src_q.push_back(8'hFF); src_q.push_back(8'h5A);
      src_q.push_back(8'hA5); src_q.push_back(8'h3C);
      drain();
      src_gap = 0;

      // stalled host: watchdog must fire (R7)
      err_seen = 0;
      host_delay = 30;
      src_q.push_back(8'hC3); src_q.push_back(8'h81);
      drain();
      chk(err_seen, "R7 timeout observed on stalled host", err_seen, 1);
      chk(timeout_err == 0, "R7 timeout cleared after phase", timeout_err, 0);

      // reset while the strobe is high (R8)
      host_delay = 10;
      src_q.push_back(8'h77);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (xmit_strobe) break;
      end
      rst = 1'b1;
      src_q.delete();
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      #1;
      chk(xmit_strobe == 0, "R8 strobe after mid reset", xmit_strobe, 0);
      chk(bus_data == 0, "R8 bus after mid reset", bus_data, 0);
      host_delay = 1;
      src_q.push_back(8'h42); src_q.push_back(8'hBD);
      drain();
      chk(exp_q.size() == 0, "R1 all words delivered", exp_q.size(), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule